// File: doc/BRIEF.md
# Odd-Even Split Stream Recombiner

A logical weight buffer can be stored as two half buffers, one holding every even address and one holding every odd address. Each half is read through its own RAM port, so the buffer reaches the compute side as two streams, each at half the rate. Because the split buffer uses both ports, it is read at twice the rate of the buffers that share a port with it. This block merges the two halves back into one stream in the original address order.

A join stage accepts one word from each half at the same time and places them side by side as a double-width pair. A 2:1 serializer then sends the even word first and the odd word second, each at the original width, on a valid/ready output. When the output stalls, backpressure reaches both input streams, and no word is lost or duplicated. If the buffer length is odd, the producer marks the odd partner of the last even word as padding. That padding word is never sent out.

Top module: `odd_even_recombiner`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `out_valid` is 0. While idle, no input is accepted unless both input valids are high.
- R2: A pair is taken only when `even_valid` and `odd_valid` are both high. `even_ready` and `odd_ready` handshakes always complete in the same cycle, so neither half is consumed alone.
- R3: Output words appear in address order. For each pair, the even word (address 2k) is sent before the odd word (address 2k+1), and pairs keep the order in which they were accepted.
- R4: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` stays unchanged in the next cycle.
- R5: When both inputs are always valid and `out_ready` is always high, the output carries one word every cycle with no gap once the first word appears. The next pair is taken in the same cycle that the last word of the previous pair leaves.
- R6: While the output is stalled (`out_valid` high, `out_ready` low), no input pair is accepted.
- R7: A pair whose `odd_pad` bit is 1 produces only its even word. The odd word is dropped, and the next output word is the even word of the following pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| even_valid | input | 1 | Even-half word available |
| even_data | input | WORD_W | Even-address word |
| even_ready | output | 1 | Even-half word accepted |
| odd_valid | input | 1 | Odd-half word available |
| odd_data | input | WORD_W | Odd-address word |
| odd_pad | input | 1 | Odd word is padding and must be dropped |
| odd_ready | output | 1 | Odd-half word accepted |
| out_valid | output | 1 | Output word available |
| out_data | output | WORD_W | Output word in address order |
| out_ready | input | 1 | Downstream accepts the output word |

## Verification
Two things can happen in the same cycle: the last word of the held pair leaves, and the next pair is loaded. This happens every cycle when both sources stay valid and the sink stays ready, and randomized valid and ready patterns make it happen next to stalls. Each output word is compared with a queue of expected words, built from the input handshakes seen at the ports. A lost, repeated or reordered word, or a gap in the full-rate phase, is reported. Padding pairs are mixed in, so a padding word that is emitted shows up as a data mismatch.

// File: rtl/oer_pkg.sv
package oer_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_EVEN = 2'd1,
        PH_ODD  = 2'd2
    } phase_t;

    // The held pair finishes on this beat if it is the odd word, or the even word of a padded pair.
    function automatic logic final_beat(phase_t ph, logic pad);
        return (ph == PH_ODD) || ((ph == PH_EVEN) && pad);
    endfunction

endpackage

// File: rtl/oer_pair_join.sv
module oer_pair_join #(
    parameter int unsigned WORD_W = 16,
    localparam int unsigned PAIR_W = 2 * WORD_W
) (
    input  logic              even_valid,
    input  logic [WORD_W-1:0] even_data,
    output logic              even_ready,
    input  logic              odd_valid,
    input  logic [WORD_W-1:0] odd_data,
    input  logic              odd_pad,
    output logic              odd_ready,
    output logic              pair_valid,
    output logic [PAIR_W-1:0] pair_data,
    output logic              pair_pad,
    input  logic              pair_ready
);
    // A word is taken only together with its partner.
    always_comb begin
        pair_valid = even_valid && odd_valid;
        pair_data  = {odd_data, even_data};
        pair_pad   = odd_pad;
        even_ready = pair_ready && odd_valid;
        odd_ready  = pair_ready && even_valid;
    end
endmodule

// File: rtl/oer_serialize.sv
module oer_serialize
    import oer_pkg::*;
#(
    parameter int unsigned WORD_W = 16,
    localparam int unsigned PAIR_W = 2 * WORD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pair_valid,
    input  logic [PAIR_W-1:0] pair_data,
    input  logic              pair_pad,
    output logic              pair_ready,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_data,
    input  logic              out_ready
);
    phase_t            ph_q;
    logic [PAIR_W-1:0] hold_q;
    logic              pad_q;
    logic              leaving;

    always_comb begin
        leaving    = out_ready && final_beat(ph_q, pad_q);
        pair_ready = (ph_q == PH_IDLE) || leaving;
        out_valid  = (ph_q != PH_IDLE);
        out_data   = (ph_q == PH_ODD) ? hold_q[PAIR_W-1:WORD_W] : hold_q[WORD_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q   <= PH_IDLE;
            hold_q <= '0;
            pad_q  <= 1'b0;
        end else if (pair_valid && pair_ready) begin
            hold_q <= pair_data;
            pad_q  <= pair_pad;
            ph_q   <= PH_EVEN;
        end else if (leaving) begin
            ph_q <= PH_IDLE;
        end else if ((ph_q == PH_EVEN) && out_ready) begin
            ph_q <= PH_ODD;
        end
    end

    // R3: the odd word is only reached from an accepted even word
    a_r3_even_first: assert property (@(posedge clk) disable iff (rst)
        (ph_q == PH_ODD) && !$past(ph_q == PH_ODD) |-> $past((ph_q == PH_EVEN) && out_ready));

    // R7: a padded pair never advances to its odd word
    a_r7_pad_dropped: assert property (@(posedge clk) disable iff (rst)
        (ph_q == PH_EVEN) && pad_q && out_ready |=> (ph_q != PH_ODD));

endmodule

// File: rtl/odd_even_recombiner.sv
module odd_even_recombiner #(
    parameter int unsigned WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              even_valid,
    input  logic [WORD_W-1:0] even_data,
    output logic              even_ready,
    input  logic              odd_valid,
    input  logic [WORD_W-1:0] odd_data,
    input  logic              odd_pad,
    output logic              odd_ready,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_data,
    input  logic              out_ready
);
    localparam int unsigned PAIR_W = 2 * WORD_W;

    logic              pr_valid;
    logic [PAIR_W-1:0] pr_data;
    logic              pr_pad;
    logic              pr_ready;

    oer_pair_join #(.WORD_W(WORD_W)) u_join (
        .even_valid (even_valid),
        .even_data  (even_data),
        .even_ready (even_ready),
        .odd_valid  (odd_valid),
        .odd_data   (odd_data),
        .odd_pad    (odd_pad),
        .odd_ready  (odd_ready),
        .pair_valid (pr_valid),
        .pair_data  (pr_data),
        .pair_pad   (pr_pad),
        .pair_ready (pr_ready)
    );

    oer_serialize #(.WORD_W(WORD_W)) u_ser (
        .clk        (clk),
        .rst        (rst),
        .pair_valid (pr_valid),
        .pair_data  (pr_data),
        .pair_pad   (pr_pad),
        .pair_ready (pr_ready),
        .out_valid  (out_valid),
        .out_data   (out_data),
        .out_ready  (out_ready)
    );

    // R2: both halves complete their handshakes together
    a_r2_joint_take: assert property (@(posedge clk) disable iff (rst)
        (even_valid && even_ready) == (odd_valid && odd_ready));

    // R4: a stalled output word is held
    a_r4_hold_stall: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_data));

    // R6: no pair enters while the output is stalled
    a_r6_backpressure: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |-> !(even_valid && even_ready));

endmodule

// File: tb/sim_odd_even_recombiner.sv
module sim_odd_even_recombiner;
    localparam int W = 16;

    logic clk = 1'b0;
    logic rst;
    logic ev_v, od_v, od_pad, out_r;
    logic [W-1:0] ev_d, od_d;
    logic ev_r, od_r, out_v;
    logic [W-1:0] out_d;

    always #4 clk = ~clk;

    odd_even_recombiner #(.WORD_W(W)) u0 (
        .clk(clk), .rst(rst),
        .even_valid(ev_v), .even_data(ev_d), .even_ready(ev_r),
        .odd_valid(od_v), .odd_data(od_d), .odd_pad(od_pad), .odd_ready(od_r),
        .out_valid(out_v), .out_data(out_d), .out_ready(out_r)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [W-1:0] expq[$];
    logic [15:0] lfsr = 16'hACE1;
    int p_ev, p_od, p_rdy, pad_every;
    int ev_idx = 0, od_idx = 0;
    bit ev_fired = 0, od_fired = 0;
    bit prev_stall = 0;
    logic [W-1:0] prev_data;
    bit full_mode = 0;
    int full_cnt = 0;

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic bit roll(int p);
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        return int'(lfsr[7:0]) < p;
    endfunction

    task automatic step();
        bit ef, of;
        @(negedge clk);
        if (ev_fired) begin ev_v = 0; ev_idx++; end
        if (od_fired) begin od_v = 0; od_idx++; end
        if (!ev_v && roll(p_ev)) begin
            ev_v = 1; ev_d = W'(16'h1000 + 2 * ev_idx);
        end
        if (!od_v && roll(p_od)) begin
            od_v = 1;
            od_pad = (pad_every != 0) && (od_idx % pad_every == pad_every - 1);
            od_d = od_pad ? W'(16'hBAD0) : W'(16'h1000 + 2 * od_idx + 1);
        end
        out_r = roll(p_rdy);
        #1;
        if (prev_stall) begin
            check(out_v == 1'b1, "R4 valid held", int'(out_v), 1);
            check(out_d == prev_data, "R4 data held", int'(out_d), int'(prev_data));
        end
        if (out_v && expq.size() == 0)
            check(0, "R3 unexpected word", int'(out_d), 0);
        if (out_v && out_r && expq.size() != 0) begin
            logic [W-1:0] e;
            e = expq.pop_front();
            check(out_d == e, "R3/R7 order", int'(out_d), int'(e));
        end
        if (full_mode) begin
            full_cnt++;
            if (full_cnt > 2) check(out_v == 1'b1, "R5 no gap", int'(out_v), 1);
        end
        ef = ev_v && ev_r;
        of = od_v && od_r;
        if (ef || of) check(ef && of, "R2 joint take", int'({ef, of}), 3);
        if (out_v && !out_r) check(!ef, "R6 stall blocks input", int'(ef), 0);
        if (ef) begin
            expq.push_back(ev_d);
            if (!od_pad) expq.push_back(od_d);
        end
        ev_fired = ef;
        od_fired = of;
        prev_stall = out_v && !out_r;
        prev_data = out_d;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1; ev_v = 0; od_v = 0; od_pad = 0; out_r = 0; ev_d = '0; od_d = '0;
        p_ev = 0; p_od = 0; p_rdy = 256; pad_every = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(out_v == 1'b0, "R1 reset valid", int'(out_v), 0);
        rst = 0;
        @(negedge clk);
        check(out_v == 1'b0, "R1 after reset", int'(out_v), 0);
        ev_v = 1; ev_d = W'(16'h1000);
        #1;
        check(ev_r == 1'b0, "R1 even alone not taken", int'(ev_r), 0);
        // R2: even held valid with no odd partner
        p_ev = 256; p_od = 0;
        for (int i = 0; i < 5; i++) begin
            step();
            check(ev_r == 1'b0, "R2 even alone", int'(ev_r), 0);
        end
        // R5: full rate
        p_od = 256; p_rdy = 256;
        full_mode = 1;
        for (int i = 0; i < 32; i++) step();
        full_mode = 0;
        // random traffic with stalls
        p_ev = 180; p_od = 150; p_rdy = 140;
        for (int i = 0; i < 600; i++) step();
        // R7: padded pairs mixed in
        pad_every = 3;
        for (int i = 0; i < 600; i++) step();
        pad_every = 0;
        p_ev = 0; p_od = 0; p_rdy = 256;
        for (int i = 0; i < 40; i++) step();
        check(expq.size() == 0, "R3 drained", expq.size(), 0);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule